// File: doc/BRIEF.md
# Mixed-Sign Byte Dot-Product Row

This block is the arithmetic core of a tile multiply engine. Each lane takes one 32-bit word from each of two operand sources and one 32-bit accumulator word. A lane word holds four 8-bit elements. The lane multiplies the element pairs in the same positions, adds the four products to the accumulator, and returns the new 32-bit accumulator value. A row of `LANES` lanes, 16 by default, is handled in every cycle.

A 2-bit mode input sets the signedness of each source on its own. This gives signed-by-signed, signed-by-unsigned, unsigned-by-signed and unsigned-by-unsigned products from one datapath.

The pipeline has two stages:
- Stage one widens every byte to 9 bits and forms the products.
- Stage two sums the products through an adder tree and adds the accumulator.

A valid bit travels with the data. The result is registered. A row sequencer outside this block walks the tile rows and columns and feeds operands.

Top module: `dp_mixdot_row`

## Requirements
- R1: For each lane, element k of a source word sits at bits 8k+7:8k, with k from 0 to 3. The lane result is the accumulator lane plus the sum over k of first-source element k times second-source element k.
- R2: Mode bit 1 set means first-source bytes are read as two's-complement values (-128..127). Mode bit 1 clear means they are read as unsigned values (0..255).
- R3: Mode bit 0 sets the signedness of second-source bytes in the same way, independently of bit 1. Encodings: 2'b11 signed×signed, 2'b10 signed×unsigned, 2'b01 unsigned×signed, 2'b00 unsigned×unsigned.
- R4: The lane sum is reduced modulo 2^32, with no saturation, in both the positive and the negative direction.
- R5: Lanes are computed independently. No value in one lane affects any other lane.
- R6: A row sampled with `in_valid` high at a rising edge appears on `out_res` with `out_valid` high after the second rising edge that follows. Rows may be presented on every cycle.
- R7: A cycle with `in_valid` low produces `out_valid` low two edges later, and `out_res` keeps its previous value.
- R8: While reset is asserted and after its release, `out_valid` is 0 and `out_res` is all zero until the first valid row comes out. Inputs presented during reset are discarded.
- R9: Every byte product lies within -32640..65025.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Row qualifier for the operand and accumulator inputs |
| in_mode | input | 2 | Signedness select: bit 1 first source, bit 0 second source |
| in_a | input | LANES*32 | First source words, lane n at bits 32n+31:32n |
| in_b | input | LANES*32 | Second source words, same lane layout |
| in_acc | input | LANES*32 | Accumulator words, same lane layout |
| out_valid | output | 1 | Result qualifier, two cycles after `in_valid` |
| out_res | output | LANES*32 | Updated accumulator words |

## Verification
The bench drives every one of the 65536 byte pairs through every mode.

- A design that swapped the roles of the two mode bits, or widened a byte with the wrong rule, would produce wrong sums in the two mixed modes. It would show up on pairs such as 0x80 with 0xFF.
- Accumulators at 0x7FFFFFFF and 0x80000000 expose a design that saturates or loses the carry out of bit 31.
- A single lane loaded with maximum values next to zero lanes catches carry or wiring bleeding between lanes.
- A known word with distinct elements catches reversed element order.
- Idle cycles inserted between rows catch a result register that updates without a valid row or drops it early.

// File: rtl/dp_pkg.sv
package dp_pkg;

  localparam int BYTE_W = 8;
  localparam int EXT_W  = BYTE_W + 1;
  localparam int PROD_W = 2 * EXT_W;
  localparam int WORD_W = 32;
  localparam int ELEMS  = WORD_W / BYTE_W;

  typedef enum logic [1:0] {
    MODE_UU = 2'b00,
    MODE_US = 2'b01,
    MODE_SU = 2'b10,
    MODE_SS = 2'b11
  } dp_mode_e;

  // Widen one byte to 9 bits: sign-fill when sgn is set, zero-fill otherwise.
  function automatic logic signed [EXT_W-1:0] widen_byte(
    input logic [BYTE_W-1:0] v,
    input logic              sgn
  );
    return $signed({sgn & v[BYTE_W-1], v});
  endfunction

endpackage

// File: rtl/dp_lane_mul.sv
module dp_lane_mul
  import dp_pkg::*;
(
  input  logic [WORD_W-1:0]       a_word,
  input  logic [WORD_W-1:0]       b_word,
  input  logic                    a_sgn,
  input  logic                    b_sgn,
  output logic [ELEMS*PROD_W-1:0] prod
);

  for (genvar e = 0; e < ELEMS; e++) begin : g_elem
    logic signed [EXT_W-1:0]  ea;
    logic signed [EXT_W-1:0]  eb;
    logic signed [PROD_W-1:0] pe;

    assign ea = widen_byte(a_word[e*BYTE_W +: BYTE_W], a_sgn);
    assign eb = widen_byte(b_word[e*BYTE_W +: BYTE_W], b_sgn);
    assign pe = ea * eb;
    assign prod[e*PROD_W +: PROD_W] = pe;
  end

endmodule

// File: rtl/dp_prod_stage.sv
module dp_prod_stage
  import dp_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [1:0]                    in_mode,
  input  logic [LANES*WORD_W-1:0]       in_a,
  input  logic [LANES*WORD_W-1:0]       in_b,
  input  logic [LANES*WORD_W-1:0]       in_acc,
  output logic                          s1_valid,
  output logic [LANES*ELEMS*PROD_W-1:0] s1_prod,
  output logic [LANES*WORD_W-1:0]       s1_acc
);

  localparam int LANE_PW = ELEMS * PROD_W;
  localparam int ROW_PW  = LANES * LANE_PW;
  localparam int ROW_AW  = LANES * WORD_W;
  localparam int signed PROD_MIN = -32640;
  localparam int signed PROD_MAX = 65025;

  logic [ROW_PW-1:0] prod_d;
  logic [ROW_PW-1:0] prod_nxt;
  logic [ROW_AW-1:0] acc_nxt;
  logic              vld_nxt;
  logic              load_en;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dp_lane_mul u_mul (
      .a_word (in_a[l*WORD_W +: WORD_W]),
      .b_word (in_b[l*WORD_W +: WORD_W]),
      .a_sgn  (in_mode[1]),
      .b_sgn  (in_mode[0]),
      .prod   (prod_d[l*LANE_PW +: LANE_PW])
    );
  end

  always_comb begin
    load_en  = in_valid;
    vld_nxt  = in_valid;
    prod_nxt = load_en ? prod_d : s1_prod;
    acc_nxt  = load_en ? in_acc : s1_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_prod  <= '0;
      s1_acc   <= '0;
    end else begin
      s1_valid <= vld_nxt;
      s1_prod  <= prod_nxt;
      s1_acc   <= acc_nxt;
    end
  end

  // R6: stage-one valid tracks the input qualifier one edge later
  a_r6_stage_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);
  a_r7_stage_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !s1_valid);
  // R7: registered products are untouched by idle cycles
  a_r7_prod_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(s1_prod));

  for (genvar i = 0; i < LANES*ELEMS; i++) begin : g_chk
    // R2 / R3: unsigned-by-unsigned never yields a negative product
    a_r2_uu_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == MODE_UU) |=> !s1_prod[i*PROD_W + PROD_W-1]);
    // R3: signed-by-signed products stay within -16256..16384
    a_r3_ss_range: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == MODE_SS) |=>
        ($signed(s1_prod[i*PROD_W +: PROD_W]) >= -16256 &&
         $signed(s1_prod[i*PROD_W +: PROD_W]) <= 16384));
    // R9: every product lies in the widened range
    a_r9_prod_range: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |-> ($signed(s1_prod[i*PROD_W +: PROD_W]) >= PROD_MIN &&
                    $signed(s1_prod[i*PROD_W +: PROD_W]) <= PROD_MAX));
  end

endmodule

// File: rtl/dp_lane_sum.sv
module dp_lane_sum
  import dp_pkg::*;
(
  input  logic [WORD_W-1:0]       acc,
  input  logic [ELEMS*PROD_W-1:0] prods,
  output logic [WORD_W-1:0]       sum
);

  // Two-level tree sized for four elements per lane.
  localparam int PAIRS  = ELEMS / 2;
  localparam int PAIR_W = PROD_W + 1;
  localparam int QUAD_W = PROD_W + 2;

  logic signed [PAIR_W-1:0] pair_s [PAIRS];
  logic signed [QUAD_W-1:0] quad_s;
  logic        [WORD_W-1:0] quad_x;

  for (genvar j = 0; j < PAIRS; j++) begin : g_pair
    logic signed [PROD_W-1:0] p_lo;
    logic signed [PROD_W-1:0] p_hi;
    assign p_lo = prods[(2*j)*PROD_W +: PROD_W];
    assign p_hi = prods[(2*j+1)*PROD_W +: PROD_W];
    assign pair_s[j] = PAIR_W'(p_lo) + PAIR_W'(p_hi);
  end

  always_comb begin
    quad_s = QUAD_W'(pair_s[0]) + QUAD_W'(pair_s[1]);
    quad_x = {{(WORD_W-QUAD_W){quad_s[QUAD_W-1]}}, quad_s};
    sum    = acc + quad_x;
  end

endmodule

// File: rtl/dp_acc_stage.sv
module dp_acc_stage
  import dp_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          s1_valid,
  input  logic [LANES*ELEMS*PROD_W-1:0] s1_prod,
  input  logic [LANES*WORD_W-1:0]       s1_acc,
  output logic                          out_valid,
  output logic [LANES*WORD_W-1:0]       out_res
);

  localparam int LANE_PW = ELEMS * PROD_W;
  localparam int ROW_AW  = LANES * WORD_W;

  logic [ROW_AW-1:0] sum_d;
  logic [ROW_AW-1:0] res_nxt;
  logic              vld_nxt;
  logic              load_en;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dp_lane_sum u_sum (
      .acc   (s1_acc[l*WORD_W +: WORD_W]),
      .prods (s1_prod[l*LANE_PW +: LANE_PW]),
      .sum   (sum_d[l*WORD_W +: WORD_W])
    );
  end

  always_comb begin
    load_en = s1_valid;
    vld_nxt = s1_valid;
    res_nxt = load_en ? sum_d : out_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else begin
      out_valid <= vld_nxt;
      out_res   <= res_nxt;
    end
  end

  // R6: result qualifier follows the stage-one qualifier
  a_r6_out_follows: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);
  // R7: idle stage one leaves the result register unchanged
  a_r7_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> (!out_valid && $stable(out_res)));

endmodule

// File: rtl/dp_mixdot_row.sv
module dp_mixdot_row
  import dp_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              in_mode,
  input  logic [LANES*WORD_W-1:0] in_a,
  input  logic [LANES*WORD_W-1:0] in_b,
  input  logic [LANES*WORD_W-1:0] in_acc,
  output logic                    out_valid,
  output logic [LANES*WORD_W-1:0] out_res
);

  logic                          s1_valid;
  logic [LANES*ELEMS*PROD_W-1:0] s1_prod;
  logic [LANES*WORD_W-1:0]       s1_acc;

  dp_prod_stage #(.LANES(LANES)) u_prod (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_mode  (in_mode),
    .in_a     (in_a),
    .in_b     (in_b),
    .in_acc   (in_acc),
    .s1_valid (s1_valid),
    .s1_prod  (s1_prod),
    .s1_acc   (s1_acc)
  );

  dp_acc_stage #(.LANES(LANES)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .s1_prod   (s1_prod),
    .s1_acc    (s1_acc),
    .out_valid (out_valid),
    .out_res   (out_res)
  );

  // R6: two edges from an accepted row to its result
  a_r6_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);

endmodule

// File: tb/sim_dp_mixdot_row.sv
module sim_dp_mixdot_row;

  localparam int CLK_P = 10;
  localparam int LANES = 16;
  localparam int AW    = LANES * 32;
  localparam int ROWS_PER_MODE = 65536 / (LANES * 4);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [1:0]    in_mode;
  logic [AW-1:0] in_a, in_b, in_acc;
  logic          out_valid;
  logic [AW-1:0] out_res;

  int checks = 0;
  int fails  = 0;

  logic          h1_v = 1'b0, h2_v = 1'b0;
  logic [AW-1:0] h1_e = '0,   h2_e = '0;
  string         h1_t = "",   h2_t = "";
  logic [AW-1:0] last_res = '0;

  always #(CLK_P/2) clk = ~clk;

  dp_mixdot_row #(.LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_a(in_a), .in_b(in_b), .in_acc(in_acc),
    .out_valid(out_valid), .out_res(out_res)
  );

  function automatic logic [AW-1:0] row_exp(input logic [1:0] m,
      input logic [AW-1:0] a, input logic [AW-1:0] b, input logic [AW-1:0] acc);
    logic [AW-1:0] r;
    for (int l = 0; l < LANES; l++) begin
      longint s = longint'(acc[l*32 +: 32]);
      for (int k = 0; k < 4; k++) begin
        logic [7:0] ab = a[l*32 + k*8 +: 8];
        logic [7:0] bb = b[l*32 + k*8 +: 8];
        longint x = m[1] ? longint'($signed(ab)) : longint'(ab);
        longint y = m[0] ? longint'($signed(bb)) : longint'(bb);
        s = s + x * y;
      end
      r[l*32 +: 32] = s[31:0];
    end
    return r;
  endfunction

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // One negedge step: check the row issued two steps ago, then drive a new one.
  task automatic step(input logic v, input logic [1:0] m, input logic [AW-1:0] a,
                      input logic [AW-1:0] b, input logic [AW-1:0] acc, input string tag);
    @(negedge clk);
    if (h2_v) begin
      chk(out_valid === 1'b1, {"R6 valid ", h2_t}, 32'(out_valid), 32'd1);
      for (int l = 0; l < LANES; l++)
        chk(out_res[l*32 +: 32] === h2_e[l*32 +: 32],
            $sformatf("%s lane %0d", h2_t, l), out_res[l*32 +: 32], h2_e[l*32 +: 32]);
      last_res = h2_e;
    end else begin
      chk(out_valid === 1'b0, "R7 idle valid", 32'(out_valid), 32'd0);
      chk(out_res === last_res, "R7 hold result", out_res[31:0], last_res[31:0]);
    end
    h2_v = h1_v; h2_e = h1_e; h2_t = h1_t;
    h1_v = v; h1_e = row_exp(m, a, b, acc); h1_t = tag;
    in_valid = v; in_mode = m; in_a = a; in_b = b; in_acc = acc;
  endtask

  task automatic idle();
    step(1'b0, 2'b00, '0, '0, '0, "idle");
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] a, b, acc;
    rst_n = 1'b0;
    in_valid = 1'b1; in_mode = 2'b11;
    in_a = '1; in_b = '1; in_acc = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R8 reset valid", 32'(out_valid), 32'd0);
    chk(out_res === '0, "R8 reset result", out_res[31:0], 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    idle(); idle();

    // R1: element order, element 0 at bits 7:0
    a = '0; b = '0; acc = '0;
    a[31:0] = 32'h0000_0001; b[31:0] = 32'h0504_0302;
    step(1'b1, 2'b00, a, b, acc, "R1 element order");
    idle();
    idle();
    chk(out_res[31:0] === 32'd2, "R1 literal lane0", out_res[31:0], 32'd2);

    // R4: wrap upward and downward
    step(1'b1, 2'b00, '1, '1, {LANES{32'h7FFF_FFFF}}, "R4 wrap up");
    step(1'b1, 2'b11, {(AW/8){8'h80}}, {(AW/8){8'h7F}}, {LANES{32'h8000_0000}}, "R4 wrap down");
    step(1'b1, 2'b00, '1, {(AW/8){8'h01}}, {LANES{32'hFFFF_FFFF}}, "R4 carry out");

    // R5: one lane at maximum, others zero
    a = '0; b = '0; acc = '0;
    a[32 +: 32] = 32'hFFFF_FFFF; b[32 +: 32] = 32'hFFFF_FFFF; acc[32 +: 32] = 32'hFFFF_FFFF;
    step(1'b1, 2'b00, a, b, acc, "R5 lane isolation");
    step(1'b1, 2'b11, a, b, acc, "R5 lane isolation signed");

    // R2 / R3: mixed-mode extremes
    step(1'b1, 2'b10, {(AW/8){8'h80}}, {(AW/8){8'hFF}}, '0, "R2 first signed");
    step(1'b1, 2'b01, {(AW/8){8'h80}}, {(AW/8){8'hFF}}, '0, "R3 second signed");
    step(1'b1, 2'b00, {(AW/8){8'hFF}}, {(AW/8){8'hFF}}, '0, "R9 max product");
    idle(); idle();

    // Exhaustive sweep of all byte pairs in every mode, with idle gaps
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < ROWS_PER_MODE; c++) begin
        string tg;
        for (int l = 0; l < LANES; l++) begin
          for (int k = 0; k < 4; k++) begin
            int p = ((c * LANES + l) * 4) + k;
            a[l*32 + k*8 +: 8] = p[15:8];
            b[l*32 + k*8 +: 8] = p[7:0];
          end
          acc[l*32 +: 32] = 32'(c * LANES + l) * 32'h9E37_79B1;
        end
        tg = (m == 3) ? "R2 R3 sweep ss" : (m == 2) ? "R2 sweep su" :
             (m == 1) ? "R3 sweep us" : "R1 sweep uu";
        if (c % 7 == 3) idle();
        step(1'b1, 2'(m), a, b, acc, tg);
      end
    end
    idle(); idle(); idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule